// File: doc/BRIEF.md
# AT-Style Expansion Bus Cycle Sizer

This block sits on the host side of an AT-style expansion bus. A CPU-side requester hands it one 16-bit read or write, either to memory space or to I/O space. The block turns that request into bus activity. It drives a latched 20-bit address, the unlatched region bits 23..17, one of four separate active-low command strobes and the 16-bit data lanes. At the end of the address phase it samples an active-low width-acknowledge from the addressed board. If the board answers, the access runs as a single 16-bit cycle. If it does not, the access is split into two 8-bit cycles on the low byte lane.

Every command strobe is held for a number of wait states set by a parameter, with one value for 16-bit cycles and another for 8-bit cycles. A board can pull the active-low zero-wait input to end the strobe in the current bus clock. When the last partial cycle finishes, the block returns a one-cycle completion pulse together with the assembled read data. It takes no new request until that point.

Top module: `busSizer`

## Requirements
- R1: The four command strobes are active low, and at most one is low at any time. The strobe is selected from {io, write}: memory read is 00, memory write is 01, I/O read is 10 and I/O write is 11.
- R2: Each partial cycle presents its address on `busAddr` and `upperAddr` for one bus clock before the strobe goes low. The address stays unchanged while the strobe is low.
- R3: `width16N` is sampled at the end of the address phase of the first partial cycle. If it is low, the access is one 16-bit cycle at the even address (`busAddr` bit 0 = 0), and the whole write word is driven on `busDout[15:0]`.
- R4: If `width16N` is high, the access becomes two 8-bit cycles. The first is at the even address and the second at the odd address (bit 0 = 1). Writes carry the low byte and then the high byte on `busDout[7:0]`. Reads take `busDin[7:0]` from each cycle, low byte first. Bit 0 of the request address is ignored.
- R5: `upperAddr` carries request address bits 23..17 for every partial cycle of the access. A board therefore acknowledges a whole 128 KiB region, and an acknowledge decoded for a different region gives a split access.
- R6: When `zeroWsN` stays high, a strobe stays low for WAIT16+1 bus clocks in a 16-bit cycle and for WAIT8+1 bus clocks in an 8-bit cycle.
- R7: `zeroWsN` is sampled on every clock in which a strobe is low. If it is sampled low, the strobe goes high after that clock, so a 1-clock strobe is possible in both 8-bit and 16-bit cycles.
- R8: `done` is high for exactly one clock. It comes a fixed number of clocks after the accepting edge: the sum, over the partial cycles, of 1 address clock, the strobe length and 1 recovery clock. For reads, `rdata` holds {byte at the odd address, byte at the even address} while `done` is high.
- R9: `reqReady` is high only when no access is in progress. A `reqValid` raised during an access is ignored and produces no bus cycle.
- R10: After reset all strobes are high, `busDoe` and `done` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqAddr | input | 24 | Request byte address (bit 0 ignored) |
| reqWdata | input | 16 | Write word |
| reqReady | output | 1 | Idle, can take a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read word, valid with done |
| memRdN | output | 1 | Memory read strobe |
| memWrN | output | 1 | Memory write strobe |
| ioRdN | output | 1 | I/O read strobe |
| ioWrN | output | 1 | I/O write strobe |
| busAddr | output | 20 | Latched address bits 19..0 |
| upperAddr | output | 7 | Unlatched region address bits 23..17 |
| busDout | output | 16 | Write data lanes |
| busDoe | output | 1 | Write data lanes enabled |
| busDin | input | 16 | Read data lanes |
| width16N | input | 1 | Board accepts a 16-bit cycle (low) |
| zeroWsN | input | 1 | End the current strobe early (low) |

## Verification
The hardest case to reach from the ports is a region mismatch. In that case a board does acknowledge, but only for a 128 KiB region other than the one on `upperAddr`, so the access must still split. The bench's board model derives `width16N` combinationally from `upperAddr` and a per-vector claimed region, which produces the matched, mismatched and absent cases. The same model answers reads with lane-dependent bytes, so lane assembly order is visible. Reaching the other hard cases needs timed stimulus. A zero-wait request applied to split accesses shows whether the early end holds in both halves. A second request raised in the middle of an access shows whether it is ignored.

// File: rtl/busSizerPkg.sv
package busSizerPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_RECOV
  } sizerState_t;

  typedef struct packed {
    logic loadReq;
    logic cmdActive;
    logic byteSel;
    logic capWord;
    logic capLow;
    logic capHigh;
  } sizerCtl_t;

endpackage

// File: rtl/busSizerCtrl.sv
module busSizerCtrl
  import busSizerPkg::*;
#(
  parameter int WAIT16 = 1,
  parameter int WAIT8  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      width16N,
  input  logic      zeroWsN,
  output logic      reqReady,
  output logic      done,
  output sizerCtl_t ctl
);

  localparam int MAXW = (WAIT16 > WAIT8) ? WAIT16 : WAIT8;
  localparam int CW   = (MAXW < 1) ? 1 : $clog2(MAXW + 1);
  localparam logic [CW-1:0] LOAD16 = CW'(WAIT16);
  localparam logic [CW-1:0] LOAD8  = CW'(WAIT8);

  sizerState_t state;
  logic [CW-1:0] waitCnt;
  logic is16;
  logic byteSel;
  logic accept;
  logic cmdEnd;

  assign accept   = reqValid && (state == ST_IDLE);
  assign cmdEnd   = (state == ST_CMD) && ((waitCnt == '0) || !zeroWsN);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl.loadReq   = accept;
    ctl.cmdActive = (state == ST_CMD);
    ctl.byteSel   = byteSel;
    ctl.capWord   = cmdEnd && is16;
    ctl.capLow    = cmdEnd && !is16 && !byteSel;
    ctl.capHigh   = cmdEnd && !is16 && byteSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      is16    <= 1'b0;
      byteSel <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            byteSel <= 1'b0;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (!byteSel) begin
            is16    <= !width16N;
            waitCnt <= !width16N ? LOAD16 : LOAD8;
          end else begin
            waitCnt <= LOAD8;
          end
          state <= ST_CMD;
        end
        ST_CMD: begin
          if (cmdEnd) state <= ST_RECOV;
          else        waitCnt <= waitCnt - 1'b1;
        end
        ST_RECOV: begin
          if (!is16 && !byteSel) begin
            byteSel <= 1'b1;
            state   <= ST_ADDR;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/busSizerData.sv
module busSizerData
  import busSizerPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LATCHED_W  = 20,
  parameter int REGION_LSB = 17
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sizerCtl_t                ctl,
  input  logic                     reqWrite,
  input  logic                     reqIo,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [15:0]              reqWdata,
  input  logic [15:0]              busDin,
  output logic [15:0]              rdata,
  output logic                     memRdN,
  output logic                     memWrN,
  output logic                     ioRdN,
  output logic                     ioWrN,
  output logic [LATCHED_W-1:0]     busAddr,
  output logic [ADDR_W-REGION_LSB-1:0] upperAddr,
  output logic [15:0]              busDout,
  output logic                     busDoe
);

  logic [ADDR_W-1:1] addrReg;
  logic [15:0] wdataReg;
  logic [15:0] rdataReg;
  logic writeReg;
  logic ioReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      writeReg <= 1'b0;
      ioReg    <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrReg  <= reqAddr[ADDR_W-1:1];
        wdataReg <= reqWdata;
        writeReg <= reqWrite;
        ioReg    <= reqIo;
      end
      if (ctl.capWord) rdataReg <= busDin;
      if (ctl.capLow)  rdataReg[7:0]  <= busDin[7:0];
      if (ctl.capHigh) rdataReg[15:8] <= busDin[7:0];
    end
  end

  assign rdata     = rdataReg;
  assign busAddr   = {addrReg[LATCHED_W-1:1], ctl.byteSel};
  assign upperAddr = addrReg[ADDR_W-1:REGION_LSB];
  assign busDout   = ctl.byteSel ? {wdataReg[15:8], wdataReg[15:8]} : wdataReg;
  assign busDoe    = ctl.cmdActive && writeReg;

  assign memRdN = !(ctl.cmdActive && !ioReg && !writeReg);
  assign memWrN = !(ctl.cmdActive && !ioReg &&  writeReg);
  assign ioRdN  = !(ctl.cmdActive &&  ioReg && !writeReg);
  assign ioWrN  = !(ctl.cmdActive &&  ioReg &&  writeReg);

endmodule

// File: rtl/busSizer.sv
module busSizer
  import busSizerPkg::*;
#(
  parameter int WAIT16 = 1,
  parameter int WAIT8  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqIo,
  input  logic [23:0] reqAddr,
  input  logic [15:0] reqWdata,
  output logic        reqReady,
  output logic        done,
  output logic [15:0] rdata,
  output logic        memRdN,
  output logic        memWrN,
  output logic        ioRdN,
  output logic        ioWrN,
  output logic [19:0] busAddr,
  output logic [6:0]  upperAddr,
  output logic [15:0] busDout,
  output logic        busDoe,
  input  logic [15:0] busDin,
  input  logic        width16N,
  input  logic        zeroWsN
);

  sizerCtl_t ctl;

  busSizerCtrl #(.WAIT16(WAIT16), .WAIT8(WAIT8)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .width16N(width16N),
    .zeroWsN(zeroWsN), .reqReady(reqReady), .done(done), .ctl(ctl)
  );

  busSizerData #(.ADDR_W(24), .LATCHED_W(20), .REGION_LSB(17)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDin(busDin), .rdata(rdata),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .busAddr(busAddr), .upperAddr(upperAddr), .busDout(busDout), .busDoe(busDoe)
  );

endmodule

// File: rtl/busSizerChecker.sv
module busSizerChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        done,
  input logic        memRdN,
  input logic        memWrN,
  input logic        ioRdN,
  input logic        ioWrN,
  input logic [19:0] busAddr,
  input logic [6:0]  upperAddr,
  input logic        busDoe
);

  logic anyStrobe;
  assign anyStrobe = !memRdN || !memWrN || !ioRdN || !ioWrN;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!memRdN, !memWrN, !ioRdN, !ioWrN})); // R1

  AST_DOE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> (!memWrN || !ioWrN)); // R1

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyStrobe) |-> ($stable(busAddr) && $stable(upperAddr))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (anyStrobe && $past(anyStrobe)) |-> ($stable(busAddr) && $stable(upperAddr))); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> !reqReady); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!anyStrobe && reqReady)); // R8

endmodule

bind busSizer busSizerChecker u_busSizerChecker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .done(done),
  .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
  .busAddr(busAddr), .upperAddr(upperAddr), .busDoe(busDoe)
);

// File: tb/busSizer_bench.sv
module busSizer_bench;

  localparam int W16 = 1;
  localparam int W8  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, done, memRdN, memWrN, ioRdN, ioWrN, busDoe;
  logic [15:0] rdata, busDout, busDin;
  logic [19:0] busAddr;
  logic [6:0] upperAddr;
  logic width16N, zeroWsN;

  // board model controls
  logic ackValid = 1'b0;
  logic [6:0] ackRegion = '0;
  logic zwsOn = 1'b0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  busSizer #(.WAIT16(W16), .WAIT8(W8)) u_busSizer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIo(reqIo), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .done(done), .rdata(rdata), .memRdN(memRdN), .memWrN(memWrN),
    .ioRdN(ioRdN), .ioWrN(ioWrN), .busAddr(busAddr), .upperAddr(upperAddr),
    .busDout(busDout), .busDoe(busDoe), .busDin(busDin),
    .width16N(width16N), .zeroWsN(zeroWsN)
  );

  function automatic logic [7:0] boardByte(input logic [19:0] a);
    return a[7:0] ^ 8'h3C ^ {4'h0, a[11:8]};
  endfunction

  logic anyStr;
  logic rdStr;
  assign anyStr   = !memRdN || !memWrN || !ioRdN || !ioWrN;
  assign rdStr    = !memRdN || !ioRdN;
  assign width16N = !(ackValid && (upperAddr == ackRegion));
  assign zeroWsN  = !(zwsOn && anyStr);
  assign busDin   = !rdStr ? 16'h0000 :
                    !width16N ? {boardByte({busAddr[19:1], 1'b1}), boardByte({busAddr[19:1], 1'b0})}
                              : {8'hEE, boardByte(busAddr)};

  // bus monitor
  int partCnt = 0;
  logic prevStr = 1'b0;
  logic [19:0] pAddr  [64];
  logic [6:0]  pUpper [64];
  logic [1:0]  pKind  [64];
  logic [15:0] pDout  [64];
  logic        pDoe   [64];
  int          pWidth [64];

  always @(negedge clk) begin
    if (anyStr) begin
      if (!prevStr) begin
        if (partCnt < 64) begin
          pAddr[partCnt]  = busAddr;
          pUpper[partCnt] = upperAddr;
          pKind[partCnt]  = {(!ioRdN || !ioWrN), (!memWrN || !ioWrN)};
          pDout[partCnt]  = busDout;
          pDoe[partCnt]   = busDoe;
          pWidth[partCnt] = 1;
        end
        partCnt = partCnt + 1;
      end else if (partCnt > 0 && partCnt <= 64) begin
        pWidth[partCnt-1] = pWidth[partCnt-1] + 1;
      end
    end
    prevStr = anyStr;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        write;
    logic        io;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic        ackOn;
    logic [6:0]  region;
    logic        zws;
    logic [1:0]  expParts;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 24'h020100, 16'h0000, 1'b1, 7'h01, 1'b0, 2'd1},
    '{1'b1, 1'b0, 24'h020102, 16'hBEEF, 1'b1, 7'h01, 1'b0, 2'd1},
    '{1'b0, 1'b1, 24'h000300, 16'h0000, 1'b0, 7'h00, 1'b0, 2'd2},
    '{1'b1, 1'b1, 24'h000302, 16'h1234, 1'b0, 7'h00, 1'b0, 2'd2},
    '{1'b0, 1'b0, 24'h0A0010, 16'h0000, 1'b1, 7'h06, 1'b0, 2'd2},
    '{1'b1, 1'b0, 24'hFE0000, 16'hA55A, 1'b1, 7'h7F, 1'b1, 2'd1},
    '{1'b0, 1'b0, 24'h0C0004, 16'h0000, 1'b0, 7'h00, 1'b1, 2'd2},
    '{1'b1, 1'b1, 24'h0003FE, 16'h0FF0, 1'b1, 7'h00, 1'b1, 2'd1},
    '{1'b0, 1'b0, 24'h1FFFFE, 16'h0000, 1'b1, 7'h0F, 1'b0, 2'd1},
    '{1'b0, 1'b1, 24'h000001, 16'h0000, 1'b0, 7'h00, 1'b0, 2'd2}
  };

  // issue one request, return clocks from accepting edge to done
  task automatic runReq(input vec_t v, output int lat, output logic [15:0] rd);
    int n;
    @(negedge clk);
    ackValid = v.ackOn; ackRegion = v.region; zwsOn = v.zws;
    reqWrite = v.write; reqIo = v.io; reqAddr = v.addr; reqWdata = v.wdata;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    lat = n;
    rd = rdata;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(memRdN && memWrN && ioRdN && ioWrN, "R10 strobes idle", {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    check(!busDoe && !done, "R10 doe/done low", {busDoe, done}, 0);
    check(reqReady, "R10 ready", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R10 ready after release", reqReady, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int base, lat, expLat, expW, nParts;
      logic [15:0] rd, expRd;
      logic [19:0] evenA;
      logic is16;
      v = VECS[i];
      base = partCnt;
      runReq(v, lat, rd);
      nParts = partCnt - base;
      is16 = v.ackOn && (v.addr[23:17] == v.region);
      evenA = {v.addr[19:1], 1'b0};
      expW = v.zws ? 1 : ((is16 ? W16 : W8) + 1);
      expLat = (is16 ? 1 : 2) * (expW + 2);
      expRd = {boardByte({evenA[19:1], 1'b1}), boardByte(evenA)};
      check(nParts == int'(v.expParts) && nParts == (is16 ? 1 : 2),
            is16 ? "R3 one cycle" : (v.ackOn ? "R5 region mismatch splits" : "R4 split count"),
            nParts, v.expParts);
      check(lat == expLat, "R8 latency", lat, expLat);
      for (int p = 0; p < nParts && p < 2; p++) begin
        int k;
        k = base + p;
        check(pKind[k] == {v.io, v.write}, "R1 strobe kind", pKind[k], {v.io, v.write});
        check(pAddr[k] == {evenA[19:1], 1'(p)}, is16 ? "R3 even address" : "R4 byte address",
              pAddr[k], {evenA[19:1], 1'(p)});
        check(pUpper[k] == v.addr[23:17], "R5 upper address", pUpper[k], v.addr[23:17]);
        check(pWidth[k] == expW, v.zws ? "R7 zero-wait strobe" : "R6 wait states", pWidth[k], expW);
        if (v.write) begin
          check(pDoe[k], "R1 write lanes enabled", pDoe[k], 1);
          if (is16) check(pDout[k] == v.wdata, "R3 write word", pDout[k], v.wdata);
          else check(pDout[k][7:0] == (p == 0 ? v.wdata[7:0] : v.wdata[15:8]),
                     "R4 write byte order", pDout[k][7:0], (p == 0 ? v.wdata[7:0] : v.wdata[15:8]));
        end
      end
      if (!v.write) check(rd == expRd, is16 ? "R3 read word" : "R4 read assembly", rd, expRd);
      @(negedge clk);
      check(!done, "R8 done one clock", done, 0);
    end

    // R9: second request during an access is ignored
    begin
      int base, n;
      logic sawWrite;
      base = partCnt;
      @(negedge clk);
      ackValid = 1'b0; zwsOn = 1'b0;
      reqWrite = 1'b0; reqIo = 1'b0; reqAddr = 24'h040020; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!reqReady, "R9 not ready while busy", reqReady, 0);
      reqWrite = 1'b1; reqIo = 1'b1; reqAddr = 24'h000500; reqWdata = 16'hDEAD; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      n = 0;
      while (!done && n < 200) begin
        @(negedge clk);
        n++;
      end
      repeat (20) @(negedge clk);
      sawWrite = 1'b0;
      for (int k = base; k < partCnt && k < 64; k++) if (pKind[k][0]) sawWrite = 1'b1;
      check(partCnt - base == 2, "R9 only accepted access ran", partCnt - base, 2);
      check(!sawWrite, "R9 ignored request made no write", sawWrite, 0);
      check(reqReady, "R9 ready again", reqReady, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule